// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This unit turns 32-bit virtual addresses into physical addresses. A virtual address splits into a 12-bit page offset and a 20-bit page number. The page number splits again into a 10-bit outer index (bits [31:22]) and a 10-bit inner index (bits [21:12]). An eight-entry, fully associative translation cache sits in front of the page tables. A request that hits in the cache is answered in the next cycle and makes no memory access. A request that misses walks the tables in memory: it reads the outer entry, then the inner entry, then fills the cache and answers.

Software programs two registers through a small write port. The table-base register holds the byte address of the outer table. The table-limit register holds the number of usable outer entries. A flush input invalidates every cached translation. An out-of-range outer index, or a table entry with its valid bit clear, ends the request with a page fault. Only one request is in flight at a time.

Top module: `xlat_two_level`

## Requirements
- R1: While and after a synchronous active-low reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and the cache holds no valid entry.
- R2: On a request accepted while its page number is cached, rsp_valid rises in the next cycle with rsp_fault 0 and rsp_paddr = {cached frame, vaddr[11:0]}, and no memory read is issued.
- R3: On a miss within range, the first read is at table_base + 4*vaddr[31:22]. The second read is at {outer_entry[31:12], vaddr[21:12], 2'b00}. The response follows in the cycle after the second read data, with rsp_paddr = {inner_entry[31:12], vaddr[11:0]}.
- R4: A missing request whose outer index is not below table_limit faults in the next cycle with no memory read. An index of table_limit-1 walks normally.
- R5: An entry with bit 0 clear faults the walk. An invalid outer entry faults in the cycle after its data arrives, and no second read is issued. An invalid inner entry faults after the second read.
- R6: Only a walk that ends without a fault fills the cache, so a repeated request hits after a success and walks again after a fault.
- R7: The cache holds 8 translations and fills them round-robin: a ninth distinct fill evicts the oldest translation and leaves the other seven in place.
- R8: flush invalidates every entry in one cycle. A request accepted in the flush cycle is treated as a miss. A walk that completes in the flush cycle leaves no cached entry.
- R9: A register write with cfg_sel 0 loads table_base and one with cfg_sel 1 loads table_limit from cfg_wdata[10:0]. A write is taken only while no walk is in progress and is otherwise dropped.
- R10: req_ready is 0 from acceptance of a missing request until its response, and at most one memory read is outstanding.
- R11: Entry bits [11:1] have no effect on the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | One-cycle word-read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry read back |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table limit |
| cfg_wdata | input | 32 | Register write data |
| flush | input | 1 | Invalidate all cached translations |

## Verification
The flush input can land in the same cycle as two other cache events. One is the lookup of a request being accepted. The other is the fill at the end of a walk. The bench provokes the first by raising flush on the same edge as a request for a cached page. It provokes the second by having its memory model raise flush in the same cycle as the second read's data. In both cases the result is judged by repeating the request afterwards and confirming, from the memory read count and the response timing, that it walks instead of hitting.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, walk states and the table-entry layout.
// Assumes 32-bit virtual addresses, 4 KB pages and 32-bit table entries.
package xlat_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int ENT_W  = 32;
    localparam int LIM_W  = IDX_W + 1;
    localparam int RSV_W  = ENT_W - PFN_W - 1;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_OUTER = 2'd1,
        WK_INNER = 2'd2
    } walk_state_e;

    // Table entry: base in the top bits, reserved middle, valid in bit 0.
    typedef struct packed {
        logic [PFN_W-1:0] base;
        logic [RSV_W-1:0] rsv;
        logic             valid;
    } pt_entry_t;

    function automatic logic [IDX_W-1:0] outer_of(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] inner_of(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: VPN_W];
    endfunction
endpackage

// File: rtl/xlat_cfg.sv
`timescale 1ns/1ps
// Module: table-base and table-limit registers.
// Assumes a write is dropped whenever the walker reports busy.
module xlat_cfg
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [VA_W-1:0]  wr_data,
    input  logic             busy,
    output logic [VA_W-1:0]  tbl_base,
    output logic [LIM_W-1:0] tbl_limit
);
    logic [VA_W-1:0]  base_q;
    logic [LIM_W-1:0] limit_q;

    // Load the selected register when idle; hold it during a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (wr_en && !busy) begin
            if (wr_sel) limit_q <= wr_data[LIM_W-1:0];
            else        base_q  <= wr_data;
        end
    end

    assign tbl_base  = base_q;
    assign tbl_limit = limit_q;

    // R9: registers hold while a walk is running
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(limit_q)));
endmodule

// File: rtl/xlat_tcache.sv
`timescale 1ns/1ps
// Module: fully associative translation cache with round-robin fill.
// Assumes a fill only follows a miss, so a tag is never stored twice.
// Flush has priority over a fill in the same cycle and masks the lookup.
module xlat_tcache
    import xlat_pkg::*;
#(
    parameter int NENT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_tag,
    output logic             look_hit,
    output logic [PFN_W-1:0] look_pfn,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_tag,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int PTR_W = (NENT > 1) ? $clog2(NENT) : 1;

    logic             vld_q [NENT];
    logic [VPN_W-1:0] tag_q [NENT];
    logic [PFN_W-1:0] pfn_q [NENT];
    logic [NENT-1:0]  match;
    logic [NENT-1:0]  vld_vec;
    logic [PTR_W-1:0] ptr_q;
    logic             do_fill;

    assign do_fill = fill_en && !flush;

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        // Compare one stored tag against the lookup tag.
        assign match[g]   = vld_q[g] && (tag_q[g] == look_tag);
        assign vld_vec[g] = vld_q[g];

        // Clear on flush, load when the pointer selects this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
                pfn_q[g] <= '0;
            end else if (flush) begin
                vld_q[g] <= 1'b0;
            end else if (fill_en && ptr_q == PTR_W'(g)) begin
                vld_q[g] <= 1'b1;
                tag_q[g] <= fill_tag;
                pfn_q[g] <= fill_pfn;
            end
        end
    end

    // Gather the frame of the single matching entry.
    always_comb begin
        look_pfn = '0;
        for (int k = 0; k < NENT; k++) begin
            if (match[k]) look_pfn = look_pfn | pfn_q[k];
        end
    end

    assign look_hit = (|match) && !flush;

    // Advance the round-robin pointer on every accepted fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (do_fill) begin
            ptr_q <= (ptr_q == PTR_W'(NENT - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R8: a flush leaves no valid entry
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));
    // R6: a page number is cached at most once
    p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // R7: each fill moves the replacement pointer
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_fill |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
// Module: request acceptance, range check and two-step table walk.
// Assumes the memory answers each one-cycle mem_req with exactly one
// mem_rvalid pulse, and that the cache lookup runs on req_vaddr.
module xlat_walker
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [VA_W-1:0]  tbl_base,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             look_hit,
    input  logic [PFN_W-1:0] look_pfn,
    output logic             mem_req,
    output logic [VA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_tag,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             busy
);
    walk_state_e     st_q;
    logic [VA_W-1:0] va_q;
    logic            accept;
    logic            in_range;
    pt_entry_t       ent;
    logic            unused_rsv;

    assign ent        = pt_entry_t'(mem_rdata);
    assign unused_rsv = ^ent.rsv;
    assign req_ready  = (st_q == WK_IDLE);
    assign busy       = (st_q != WK_IDLE);
    assign accept     = req_valid && req_ready;
    assign in_range   = {1'b0, outer_of(req_vaddr)} < tbl_limit;

    // Drive the fill port from the inner entry as it arrives.
    assign fill_en  = (st_q == WK_INNER) && mem_rvalid && ent.valid;
    assign fill_tag = vpn_of(va_q);
    assign fill_pfn = ent.base;

    // Sequence one request: hit, range fault, or outer then inner read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= WK_IDLE;
            va_q      <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            mem_req   <= 1'b0;
            case (st_q)
                WK_IDLE: begin
                    if (accept) begin
                        va_q <= req_vaddr;
                        if (look_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= {look_pfn, req_vaddr[OFF_W-1:0]};
                        end else if (!in_range) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_paddr <= '0;
                        end else begin
                            st_q     <= WK_OUTER;
                            mem_req  <= 1'b1;
                            mem_addr <= tbl_base +
                                {{(VA_W-IDX_W-2){1'b0}}, outer_of(req_vaddr), 2'b00};
                        end
                    end
                end
                WK_OUTER: begin
                    if (mem_rvalid) begin
                        if (!ent.valid) begin
                            st_q      <= WK_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_paddr <= '0;
                        end else begin
                            st_q     <= WK_INNER;
                            mem_req  <= 1'b1;
                            mem_addr <= {ent.base, inner_of(va_q), 2'b00};
                        end
                    end
                end
                WK_INNER: begin
                    if (mem_rvalid) begin
                        st_q      <= WK_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_fault <= !ent.valid;
                        rsp_paddr <= ent.valid ? {ent.base, va_q[OFF_W-1:0]} : '0;
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    // R2: a hit answers next cycle without fault, offset carried through
    p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && look_hit) |=>
            (rsp_valid && !rsp_fault && !mem_req &&
             rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
    // R4: out-of-range miss faults next cycle with no read
    p_limit_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !look_hit && !in_range) |=> (rsp_valid && rsp_fault && !mem_req));
    // R3: inner data produces the response in the following cycle
    p_inner_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_INNER && mem_rvalid) |=> (rsp_valid && st_q == WK_IDLE));
    // R5: invalid outer entry faults without a second read
    p_outer_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_OUTER && mem_rvalid && !ent.valid) |=>
            (rsp_valid && rsp_fault && !mem_req));
    // R10: no request is taken while a read is being issued
    p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
endmodule

// File: rtl/xlat_two_level.sv
`timescale 1ns/1ps
// Module: top of the two-level page translation unit.
// Joins the register file, the translation cache and the walker.
// Assumes one request in flight and a memory that returns one word per read.
module xlat_two_level
    import xlat_pkg::*;
#(
    parameter int NENT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        flush
);
    logic [VA_W-1:0]  tbl_base;
    logic [LIM_W-1:0] tbl_limit;
    logic             busy;
    logic             look_hit;
    logic [PFN_W-1:0] look_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_tag;
    logic [PFN_W-1:0] fill_pfn;

    xlat_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .busy      (busy),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit)
    );

    xlat_tcache #(.NENT(NENT)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_tag (vpn_of(req_vaddr)),
        .look_hit (look_hit),
        .look_pfn (look_pfn),
        .flush    (flush),
        .fill_en  (fill_en),
        .fill_tag (fill_tag),
        .fill_pfn (fill_pfn)
    );

    xlat_walker u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .tbl_base   (tbl_base),
        .tbl_limit  (tbl_limit),
        .look_hit   (look_hit),
        .look_pfn   (look_pfn),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fill_en    (fill_en),
        .fill_tag   (fill_tag),
        .fill_pfn   (fill_pfn),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_paddr  (rsp_paddr),
        .busy       (busy)
    );
endmodule

// File: tb/xlat_two_level_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard driven by a request task, a memory model that serves
// table reads, and a monitor that compares every response.
module xlat_two_level_bench;
    localparam bit [31:0] TBASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        flush_main = 1'b0;
    logic        flush_mem;
    logic        flush;

    assign flush = flush_main | flush_mem;

    always #2.5 clk = ~clk;

    xlat_two_level u_xlat_two_level (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .flush(flush)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int rsp_seen = 0;
    int mem_lat = 2;
    int rd_count = 0;
    int flush_at_read = -1;
    int last_rv_cyc = 0;
    bit [31:0] pmem [bit [31:0]];

    typedef struct {
        bit        fault;
        bit [31:0] pa;
        int        reads;
        int        rd_start;
        int        when;
        string     tag;
    } exp_t;
    exp_t sbq [$];
    exp_t mon_e;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input bit [31:0] act, input bit [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    function automatic bit [31:0] va_of(input int o, input int i, input int off);
        return {o[9:0], i[9:0], off[11:0]};
    endfunction

    // Outer entry and inner entry carry junk in bits [11:1] (R11).
    function automatic void map_page(input int o, input int i, input bit [19:0] pfn);
        bit [31:0] tbl;
        tbl = 32'h0002_0000 + o * 32'h1000;
        pmem[TBASE + o * 4] = {tbl[31:12], 12'h6A5};
        pmem[tbl + i * 4]   = {pfn, 12'h3F1};
    endfunction

    // Memory model: one read at a time, mem_lat cycles of latency.
    initial begin
        bit [31:0] a;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        flush_mem  = 1'b0;
        forever begin
            @(negedge clk);
            while (mem_req) begin
                a = mem_addr;
                repeat (mem_lat) @(negedge clk);
                rd_count++;
                mem_rvalid  = 1'b1;
                mem_rdata   = pmem.exists(a) ? pmem[a] : 32'h0;
                flush_mem   = (rd_count == flush_at_read);
                last_rv_cyc = cyc + 1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
                flush_mem  = 1'b0;
            end
        end
    end

    // Monitor: pop the expected item and compare value, reads and timing.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10", "response with nothing pending", rsp_paddr, 32'h0);
            end else begin
                mon_e = sbq.pop_front();
                chk(rsp_fault == mon_e.fault, mon_e.tag, "fault", 32'(rsp_fault), 32'(mon_e.fault));
                if (!mon_e.fault)
                    chk(rsp_paddr == mon_e.pa, mon_e.tag, "paddr", rsp_paddr, mon_e.pa);
                chk(rd_count - mon_e.rd_start == mon_e.reads, mon_e.tag, "memory reads",
                    32'(rd_count - mon_e.rd_start), 32'(mon_e.reads));
                if (mon_e.reads == 0)
                    chk(cyc == mon_e.when, mon_e.tag, "response cycle", 32'(cyc), 32'(mon_e.when));
                else
                    chk(cyc == last_rv_cyc, mon_e.tag, "response after last read",
                        32'(cyc), 32'(last_rv_cyc));
            end
            rsp_seen++;
        end
    end

    // Driver: present a request, push the expected result, await the answer.
    task automatic xlate(input bit [31:0] va, input bit f, input bit [31:0] pa,
                         input int reads, input bit with_flush, input string tag);
        exp_t e;
        int seen0;
        int t;
        seen0 = rsp_seen;
        @(negedge clk);
        req_valid  = 1'b1;
        req_vaddr  = va;
        flush_main = with_flush;
        while (!req_ready) @(negedge clk);
        e.fault = f; e.pa = pa; e.reads = reads; e.rd_start = rd_count;
        e.when = cyc + 1; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_valid  = 1'b0;
        flush_main = 1'b0;
        t = 0;
        while (rsp_seen == seen0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (rsp_seen == seen0) chk(1'b0, tag, "no response", 32'h0, 32'h1);
    endtask

    task automatic cfg_write(input bit sel, input bit [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic flush_pulse();
        @(negedge clk);
        flush_main = 1'b1;
        @(negedge clk);
        flush_main = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0, "R1", "idle after reset",
            {30'h0, req_ready, mem_req}, 32'h2);

        // R9: sel 0 base, sel 1 limit
        cfg_write(1'b0, TBASE);
        cfg_write(1'b1, 32'd4);
        map_page(1, 3, 20'h12345);
        map_page(3, 0, 20'h0ABCD);
        map_page(1, 9, 20'h00777);

        // R1 empty cache, R3 full walk
        xlate(va_of(1, 3, 12'h123), 0, {20'h12345, 12'h123}, 2, 0, "R3");
        // R2 and R6: same page now hits
        xlate(va_of(1, 3, 12'hFFF), 0, {20'h12345, 12'hFFF}, 0, 0, "R2");
        // R4: index equal to limit faults, limit-1 walks
        xlate(va_of(4, 0, 0), 1, 32'h0, 0, 0, "R4");
        xlate(va_of(3, 0, 12'h010), 0, {20'h0ABCD, 12'h010}, 2, 0, "R4");
        // R5 outer invalid, then R6 no fill
        xlate(va_of(2, 0, 0), 1, 32'h0, 1, 0, "R5");
        xlate(va_of(2, 0, 0), 1, 32'h0, 1, 0, "R6");
        // R5 inner invalid, then R6 no fill
        xlate(va_of(1, 7, 0), 1, 32'h0, 2, 0, "R5");
        xlate(va_of(1, 7, 0), 1, 32'h0, 2, 0, "R6");
        // R11 with single-cycle memory latency
        mem_lat = 1;
        xlate(va_of(1, 9, 12'hABC), 0, {20'h00777, 12'hABC}, 2, 0, "R11");
        mem_lat = 2;

        // R8: standalone flush, then refill and hit
        flush_pulse();
        xlate(va_of(1, 3, 12'h005), 0, {20'h12345, 12'h005}, 2, 0, "R8");
        xlate(va_of(1, 3, 12'h006), 0, {20'h12345, 12'h006}, 0, 0, "R2");
        // R8: flush on the acceptance edge forces a walk
        xlate(va_of(1, 3, 12'h007), 0, {20'h12345, 12'h007}, 2, 1, "R8");
        // R8: flush in the fill cycle leaves nothing cached
        map_page(3, 5, 20'h0BEEF);
        flush_at_read = rd_count + 2;
        xlate(va_of(3, 5, 0), 0, {20'h0BEEF, 12'h000}, 2, 0, "R8");
        flush_at_read = -1;
        xlate(va_of(3, 5, 12'h044), 0, {20'h0BEEF, 12'h044}, 2, 0, "R8");

        // R7: round-robin over 8 entries
        cfg_write(1'b1, 32'd16);
        flush_pulse();
        for (int k = 0; k < 9; k++) begin
            map_page(5, k, 20'h50000 + 20'(k));
            xlate(va_of(5, k, 0), 0, {20'h50000 + 20'(k), 12'h000}, 2, 0, "R7");
        end
        xlate(va_of(5, 1, 1), 0, {20'h50001, 12'h001}, 0, 0, "R7");
        xlate(va_of(5, 8, 1), 0, {20'h50008, 12'h001}, 0, 0, "R7");
        xlate(va_of(5, 0, 1), 0, {20'h50000, 12'h001}, 2, 0, "R7");
        xlate(va_of(5, 1, 2), 0, {20'h50001, 12'h002}, 2, 0, "R7");

        // R9 and R10: a limit write during a walk is dropped
        mem_lat = 4;
        map_page(6, 0, 20'h06000);
        map_page(6, 1, 20'h06001);
        fork
            xlate(va_of(6, 0, 0), 0, {20'h06000, 12'h000}, 2, 0, "R9");
            begin
                repeat (3) @(negedge clk);
                chk(req_ready == 1'b0, "R10", "req_ready during walk", 32'(req_ready), 32'h0);
                cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'd0;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        mem_lat = 2;
        xlate(va_of(6, 1, 0), 0, {20'h06001, 12'h000}, 2, 0, "R9");
        // R9: the same write while idle takes effect
        cfg_write(1'b1, 32'd0);
        xlate(va_of(6, 2, 0), 1, 32'h0, 0, 0, "R9");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R10", "pending expectations", 32'(sbq.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule